// File: doc/BRIEF.md
# Dual-Stage Watchdog Timer

This block is a watchdog with two register frames on a simple word-addressed register bus: a kick frame, where any write at offset 0x000 counts as a refresh, and a control frame holding the enable and status flags, a 32-bit period and a read-only 64-bit deadline. The watchdog watches a free-running 64-bit system counter that comes from outside the block. On every refresh it sets the deadline to the current counter value plus the period.

When the watchdog is enabled and the counter reaches the deadline, the block escalates in two steps. The first expiry raises a warning flag and a level interrupt. It also moves the deadline one more period ahead. If that second deadline passes with no refresh, the block raises a bite flag and a level reset request. Software can run the block in a single-stage style by ignoring the interrupt. In that case the reset arrives two periods after the last refresh.

Any write to the control register also counts as a refresh, and so does a write to the period register. Writing zero to the control register stops the watchdog. Both frames return fixed identification words at 0xFCC and 0xFD0.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset, enable, warning and bite are 0. The period and deadline read as 0. `irq_warn` and `rst_req` are low.
- R2: A kick-frame write at offset 0x000 sets deadline = counter + period and clears warning and bite. A kick-frame write at any other offset changes nothing.
- R3: A write to the period register (control offset 0x008) stores the value and refreshes. The deadline becomes counter plus the new period, and warning and bite clear.
- R4: A write to the control register (offset 0x000) loads enable from data bit 0 and refreshes with the current period. Data bits 1 and 2 of that write are ignored.
- R5: The warning flag sets when the watchdog is enabled, warning is clear, there is no refresh and counter >= deadline. In the same cycle the deadline reloads to counter + period. `irq_warn` is high while warning is set.
- R6: The bite flag sets when warning is already set and counter >= deadline again with no refresh. `rst_req` is high while bite is set and the watchdog is enabled.
- R7: While disabled, the warning and bite flags never set, whatever the counter value.
- R8: The control register reads enable in bit 0, warning in bit 1 and bite in bit 2. The period reads at 0x008, the deadline low word at 0x010 and the deadline high word at 0x014. Both frames read the interface word at 0xFCC and the identity word at 0xFD0. All other offsets read 0.
- R9: Writes to the deadline words and to the identification words are ignored.
- R10: Once set, bite and warning stay set until the next refresh.
- R11: Writing 0 to the control register clears enable, warning and bite, so `rst_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_cnt | input | 64 | Free-running system counter value |
| kick_wr | input | 1 | Kick-frame write strobe (write data carries no meaning) |
| kick_addr | input | 12 | Kick-frame byte offset |
| kick_rdata | output | 32 | Kick-frame read data (combinational on kick_addr) |
| ctl_wr | input | 1 | Control-frame write strobe |
| ctl_addr | input | 12 | Control-frame byte offset |
| ctl_wdata | input | 32 | Control-frame write data |
| ctl_rdata | output | 32 | Control-frame read data (combinational on ctl_addr) |
| irq_warn | output | 1 | First-stage warning interrupt, level high |
| rst_req | output | 1 | Second-stage reset request, level high |

## Verification
The assertions assume that the counter input is stable across each rising edge and that a write strobe is present for exactly the cycle meant to act. They also assume that no flag changes except through a refresh or an expiry. The bench drives the counter and the strobes only on falling edges, and it sets the counter directly to chosen values instead of letting it run. This puts every expiry at a known edge and lets the bench compute the expected deadline exactly. Counter values are also moved backwards across refreshes, which stays legal because each refresh rebases the deadline.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  // offsets that software depends on
  localparam addr_t OFS_KICK  = 12'h000;
  localparam addr_t OFS_CTRL  = 12'h000;
  localparam addr_t OFS_PER   = 12'h008;
  localparam addr_t OFS_DL_LO = 12'h010;
  localparam addr_t OFS_DL_HI = 12'h014;
  localparam addr_t OFS_IFID  = 12'hFCC;
  localparam addr_t OFS_ID    = 12'hFD0;

  // control register bit positions
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_WARN = 1;
  localparam int unsigned BIT_BITE = 2;

  function automatic word_t ident_word(addr_t a, word_t ifid, word_t id);
    word_t r;
    r = '0;
    if (a == OFS_IFID) r = ifid;
    else if (a == OFS_ID) r = id;
    return r;
  endfunction
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
#(
  parameter int unsigned PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  addr_t            ctl_addr,
  input  word_t            ctl_wdata,
  input  logic             kick_wr,
  input  addr_t            kick_addr,
  output logic             en_q,
  output logic [PER_W-1:0] per_q,
  output logic [PER_W-1:0] per_load,
  output logic             refresh
);
  logic             hit_ctrl, hit_per, hit_kick;
  logic             en_d;
  logic [PER_W-1:0] per_d;

  always_comb begin
    hit_ctrl = ctl_wr && (ctl_addr == OFS_CTRL);
    hit_per  = ctl_wr && (ctl_addr == OFS_PER);
    hit_kick = kick_wr && (kick_addr == OFS_KICK);
    refresh  = hit_ctrl || hit_per || hit_kick;
    en_d     = hit_ctrl ? ctl_wdata[BIT_EN] : en_q;
    per_d    = hit_per ? ctl_wdata[PER_W-1:0] : per_q;
    per_load = per_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      per_q <= '0;
    end else begin
      if (hit_ctrl) en_q  <= en_d;
      if (hit_per)  per_q <= per_d;
    end
  end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  input  logic             refresh,
  input  logic [PER_W-1:0] per_q,
  input  logic [PER_W-1:0] per_load,
  output logic [CNT_W-1:0] dl_q,
  output logic             warn_q,
  output logic             bite_q
);
  logic [CNT_W-1:0] dl_d;
  logic             warn_d, bite_d, due, upd;

  always_comb begin
    dl_d   = dl_q;
    warn_d = warn_q;
    bite_d = bite_q;
    due    = en && (cnt >= dl_q);
    if (refresh) begin
      dl_d   = cnt + CNT_W'(per_load);
      warn_d = 1'b0;
      bite_d = 1'b0;
    end else if (due) begin
      if (!warn_q) begin
        warn_d = 1'b1;
        dl_d   = cnt + CNT_W'(per_q);
      end else begin
        bite_d = 1'b1;
      end
    end
    upd = refresh || due;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q   <= '0;
      warn_q <= 1'b0;
      bite_q <= 1'b0;
    end else if (upd) begin
      dl_q   <= dl_d;
      warn_q <= warn_d;
      bite_q <= bite_d;
    end
  end
endmodule

// File: rtl/wdt_rd_mux.sv
module wdt_rd_mux
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned PER_W   = 32,
  parameter word_t       IFID_VAL = 32'h0000_1A57,
  parameter word_t       ID_VAL   = 32'h0000_0D0E
) (
  input  addr_t            ctl_addr,
  input  addr_t            kick_addr,
  input  logic             en,
  input  logic             warn,
  input  logic             bite,
  input  logic [PER_W-1:0] per,
  input  logic [CNT_W-1:0] dl,
  output word_t            ctl_rdata,
  output word_t            kick_rdata
);
  localparam int unsigned WIDE = 2 * DATA_W;
  logic [WIDE-1:0] dl_wide;

  always_comb begin
    dl_wide = WIDE'(dl);
    unique case (ctl_addr)
      OFS_CTRL: begin
        ctl_rdata           = '0;
        ctl_rdata[BIT_EN]   = en;
        ctl_rdata[BIT_WARN] = warn;
        ctl_rdata[BIT_BITE] = bite;
      end
      OFS_PER:   ctl_rdata = DATA_W'(per);
      OFS_DL_LO: ctl_rdata = dl_wide[DATA_W-1:0];
      OFS_DL_HI: ctl_rdata = dl_wide[WIDE-1:DATA_W];
      default:   ctl_rdata = ident_word(ctl_addr, IFID_VAL, ID_VAL);
    endcase
    kick_rdata = ident_word(kick_addr, IFID_VAL, ID_VAL);
  end
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned PER_W    = 32,
  parameter word_t       IFID_VAL = 32'h0000_1A57,
  parameter word_t       ID_VAL   = 32'h0000_0D0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  logic              kick_wr,
  input  logic [ADDR_W-1:0] kick_addr,
  output logic [DATA_W-1:0] kick_rdata,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  output logic              irq_warn,
  output logic              rst_req
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             en_q, refresh, warn_q, bite_q;
  logic [PER_W-1:0] per_q, per_load;
  logic [CNT_W-1:0] dl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wdt_ctrl_regs #(.PER_W(PER_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .kick_wr(kick_wr), .kick_addr(kick_addr),
    .en_q(en_q), .per_q(per_q), .per_load(per_load), .refresh(refresh)
  );

  wdt_stage #(.CNT_W(CNT_W), .PER_W(PER_W)) u_stage (
    .clk(clk), .rst_n(rst_sync_n), .cnt(sys_cnt), .en(en_q),
    .refresh(refresh), .per_q(per_q), .per_load(per_load),
    .dl_q(dl_q), .warn_q(warn_q), .bite_q(bite_q)
  );

  wdt_rd_mux #(.CNT_W(CNT_W), .PER_W(PER_W), .IFID_VAL(IFID_VAL), .ID_VAL(ID_VAL)) u_rd (
    .ctl_addr(ctl_addr), .kick_addr(kick_addr), .en(en_q), .warn(warn_q),
    .bite(bite_q), .per(per_q), .dl(dl_q),
    .ctl_rdata(ctl_rdata), .kick_rdata(kick_rdata)
  );

  assign irq_warn = warn_q;
  assign rst_req  = bite_q && en_q;
endmodule

// File: rtl/dual_stage_wdt_chk.sv
module dual_stage_wdt_chk #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned PER_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             refresh,
  input logic             en,
  input logic             warn,
  input logic             bite,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] dl,
  input logic [PER_W-1:0] per
);
  // R5
  warn_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !warn && !refresh && (cnt >= dl)) |=>
      (warn && (dl == $past(cnt) + CNT_W'($past(per)))));

  // R6
  bite_needs_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite |-> warn);

  // R2
  refresh_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (!warn && !bite));

  // R7
  idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !refresh) |=> ($stable(warn) && $stable(bite)));

  // R10
  bite_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bite && !refresh) |=> bite);
endmodule

bind dual_stage_wdt dual_stage_wdt_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .refresh(refresh), .en(en_q),
  .warn(warn_q), .bite(bite_q), .cnt(sys_cnt), .dl(dl_q), .per(per_q)
);

// File: tb/dual_stage_wdt_bench.sv
module dual_stage_wdt_bench;
  localparam logic [31:0] IFID = 32'h0000_1A57;
  localparam logic [31:0] IDV  = 32'h0000_0D0E;

  logic        clk, rst_n;
  logic [63:0] sys_cnt;
  logic        kick_wr, ctl_wr;
  logic [11:0] kick_addr, ctl_addr;
  logic [31:0] ctl_wdata, kick_rdata, ctl_rdata;
  logic        irq_warn, rst_req;
  int          n_tests, n_fail;

  dual_stage_wdt #(.CNT_W(64), .PER_W(32), .IFID_VAL(IFID), .ID_VAL(IDV)) u_dual_stage_wdt (
    .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
    .kick_wr(kick_wr), .kick_addr(kick_addr), .kick_rdata(kick_rdata),
    .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .irq_warn(irq_warn), .rst_req(rst_req)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [11:0] a, input logic [31:0] d);
    ctl_addr = a; ctl_wdata = d; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic kick_write(input logic [11:0] a);
    kick_addr = a; kick_wr = 1'b1;
    @(negedge clk);
    kick_wr = 1'b0;
  endtask

  task automatic ctl_read(input logic [11:0] a, output logic [31:0] d);
    ctl_addr = a; #1; d = ctl_rdata;
  endtask

  task automatic kick_read(input logic [11:0] a, output logic [31:0] d);
    kick_addr = a; #1; d = kick_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    ctl_read(12'h000, d); check("R1 control", d, 0);
    ctl_read(12'h008, d); check("R1 period", d, 0);
    ctl_read(12'h010, d); check("R1 deadline", d, 0);
    check("R1 irq_warn", irq_warn, 0);
    check("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    ctl_read(12'hFCC, d);  check("R8 ctl ifid", d, IFID);
    ctl_read(12'hFD0, d);  check("R8 ctl id", d, IDV);
    kick_read(12'hFCC, d); check("R8 kick ifid", d, IFID);
    kick_read(12'hFD0, d); check("R8 kick id", d, IDV);
    kick_read(12'h000, d); check("R8 kick 0 reads 0", d, 0);
    ctl_read(12'h004, d);  check("R8 unmapped", d, 0);
    ctl_write(12'h010, 32'hFFFF_FFFF);
    ctl_write(12'h014, 32'h1234_5678);
    ctl_write(12'hFCC, 32'h0);
    ctl_read(12'h010, d);  check("R9 deadline lo ro", d, 0);
    ctl_read(12'h014, d);  check("R9 deadline hi ro", d, 0);
    ctl_read(12'hFCC, d);  check("R9 ifid ro", d, IFID);
  endtask

  task automatic t_period;
    logic [31:0] d;
    sys_cnt = 64'h1_0000_0010;
    ctl_write(12'h008, 32'h20);
    ctl_read(12'h008, d); check("R3 period", d, 32'h20);
    ctl_read(12'h010, d); check("R3 deadline lo", d, 32'h30);
    ctl_read(12'h014, d); check("R8 deadline hi", d, 32'h1);
  endtask

  task automatic t_expire;
    logic [31:0] d;
    sys_cnt = 64'd100;
    ctl_write(12'h008, 32'd10);
    ctl_write(12'h000, 32'h7);
    ctl_read(12'h000, d); check("R4 en only", d, 32'h1);
    ctl_read(12'h010, d); check("R4 deadline", d, 32'd110);
    sys_cnt = 64'd109; tick(1);
    ctl_read(12'h000, d); check("R5 not yet", d, 32'h1);
    sys_cnt = 64'd110; tick(1);
    ctl_read(12'h000, d); check("R5 warn", d, 32'h3);
    check("R5 irq", irq_warn, 1);
    ctl_read(12'h010, d); check("R5 reload", d, 32'd120);
    sys_cnt = 64'd119; tick(1);
    check("R6 no bite yet", rst_req, 0);
    sys_cnt = 64'd120; tick(1);
    ctl_read(12'h000, d); check("R6 bite", d, 32'h7);
    check("R6 rst_req", rst_req, 1);
    sys_cnt = 64'd500; tick(3);
    ctl_read(12'h000, d); check("R10 sticky", d, 32'h7);
    check("R10 irq held", irq_warn, 1);
  endtask

  task automatic t_kick;
    logic [31:0] d;
    kick_write(12'h004);
    ctl_read(12'h000, d); check("R2 other offset", d, 32'h7);
    sys_cnt = 64'd600;
    kick_write(12'h000);
    ctl_read(12'h000, d); check("R2 kick clears", d, 32'h1);
    ctl_read(12'h010, d); check("R2 deadline", d, 32'd610);
    check("R2 rst_req low", rst_req, 0);
    sys_cnt = 64'd610; tick(1);
    ctl_read(12'h000, d); check("R5 warn again", d, 32'h3);
    ctl_write(12'h000, 32'h1);
    ctl_read(12'h000, d); check("R4 ctrl refresh", d, 32'h1);
    ctl_read(12'h010, d); check("R4 deadline", d, 32'd620);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    sys_cnt = 64'd620; tick(1);
    sys_cnt = 64'd630; tick(1);
    check("R6 pre-stop rst", rst_req, 1);
    sys_cnt = 64'd700;
    ctl_write(12'h000, 32'h0);
    ctl_read(12'h000, d); check("R11 stopped", d, 0);
    check("R11 rst_req", rst_req, 0);
    ctl_read(12'h010, d); check("R11 deadline", d, 32'd710);
    sys_cnt = 64'd900; tick(5);
    ctl_read(12'h000, d); check("R7 idle", d, 0);
    check("R7 irq", irq_warn, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; sys_cnt = '0;
    kick_wr = 1'b0; kick_addr = '0;
    ctl_wr = 1'b0; ctl_addr = '0; ctl_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_map();
    t_period();
    t_expire();
    t_kick();
    t_stop();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule